// File: doc/BRIEF.md
# Biphase Block Payload Decoder

This block turns a fixed-length block of biphase-coded bytes into plain data bytes. Every incoming byte carries a row of two-bit symbols; a symbol whose two bits differ stands for one data bit, and a symbol whose two bits are equal is a coding violation. Each encoded byte therefore shrinks to a nibble. Two consecutive nibbles are joined into one output byte, with the first byte of the pair supplying the upper half. With the default parameters a block is 26 encoded bytes and yields 13 decoded bytes.

A start strobe opens a block. It clears the error accumulator and the pair phase, and it aborts any block still in progress. Encoded bytes then arrive with a valid qualifier, and idle cycles between them are allowed. Decoded bytes leave with a one-cycle valid pulse. One cycle after the final encoded byte, a done pulse is raised together with a block error flag. The flag is the OR of every coding violation seen anywhere in the block. A single bad symbol therefore marks the whole block as unusable. The flag stays put until the next start.

Top module: `bph_block_dec`

## Requirements
- R1: Bits [2k+1:2k] of an encoded byte form symbol k, and symbol k decodes to bit k of the nibble. With the default polarity, symbol 2'b10 decodes to 1 and 2'b01 decodes to 0. With the inverted polarity, 2'b01 decodes to 1 and 2'b10 decodes to 0.
- R2: A symbol of 2'b00 or 2'b11 is a coding violation. It contributes a 0 data bit to its nibble, and the byte still produces output.
- R3: The first accepted byte of each pair gives bits [7:4] of the output byte and the second gives bits [3:0]. out_valid_o pulses for one cycle, in the cycle after the second byte of the pair is accepted.
- R4: A block of BLOCK_BYTES accepted bytes (26 by default) yields BLOCK_BYTES/2 output bytes. done_o pulses for one cycle, one cycle after the last byte is accepted, coinciding with the final out_valid_o.
- R5: When done_o is high, blk_err_o is the OR of the violations of all bytes of the block. It holds that value until the next start.
- R6: start_i clears the error accumulator and the pair phase and opens a new block. A block in progress is abandoned, including any upper nibble still waiting for its partner. A byte presented in the same cycle as start_i is dropped.
- R7: Bytes presented while no block is open are ignored: they give no output and leave blk_err_o unchanged. No block is open after reset until the first start, and none is open after a block has completed.
- R8: After reset, out_valid_o, done_o and blk_err_o are 0.
- R9: Idle cycles between accepted bytes do not change the decoded bytes or the pairing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Opens a new block, clearing error and pair phase |
| in_valid_i | input | 1 | Encoded byte qualifier |
| in_byte_i | input | IN_W | Encoded byte, IN_W/2 biphase symbols |
| out_valid_o | output | 1 | Decoded byte valid pulse |
| out_byte_o | output | IN_W | Decoded byte, upper nibble first in the pair |
| done_o | output | 1 | Pulse one cycle after the block's last byte |
| blk_err_o | output | 1 | Accumulated violation flag of the block |

## Verification
The main instance uses the defaults: 8-bit bytes, 26-byte blocks and normal polarity. With those settings the bench covers full blocks, violations in the first and the last byte, aborted partial blocks, a byte dropped under start, and ignored bytes once the block has closed. A second instance is built with 4-byte blocks and inverted polarity. It reaches the opposite symbol mapping and a block end after only two output bytes, which shows that the count limit and the polarity variant follow their parameters.

// File: rtl/bph_pkg.sv
package bph_pkg;
   // Which differing symbol stands for a one bit
   typedef enum logic {
      SYM_HI_IS_ONE = 1'b0,   // 2'b10 -> 1, 2'b01 -> 0
      SYM_LO_IS_ONE = 1'b1    // 2'b01 -> 1, 2'b10 -> 0
   } sym_pol_e;
endpackage

// File: rtl/bph_sym_dec.sv
module bph_sym_dec #(
   parameter bph_pkg::sym_pol_e POL = bph_pkg::SYM_HI_IS_ONE
) (
   input  logic [1:0] sym_i,
   output logic       bit_o,
   output logic       bad_o
);
   // equal halves are a coding violation
   assign bad_o = ~(sym_i[1] ^ sym_i[0]);

   generate
      if (POL == bph_pkg::SYM_HI_IS_ONE) begin : g_hi
         assign bit_o = (sym_i == 2'b10);
      end else begin : g_lo
         assign bit_o = (sym_i == 2'b01);
      end
   endgenerate
endmodule

// File: rtl/bph_byte_dec.sv
module bph_byte_dec #(
   parameter int                  IN_W = 8,
   parameter bph_pkg::sym_pol_e   POL  = bph_pkg::SYM_HI_IS_ONE,
   localparam int                 NSYM = IN_W / 2
) (
   input  logic [IN_W-1:0] byte_i,
   output logic [NSYM-1:0] nib_o,
   output logic            err_o
);
   logic [NSYM-1:0] bad;

   generate
      for (genvar k = 0; k < NSYM; k++) begin : g_sym
         bph_sym_dec #(.POL(POL)) u_sym (
            .sym_i (byte_i[2*k+1:2*k]),
            .bit_o (nib_o[k]),
            .bad_o (bad[k])
         );
      end
   endgenerate

   assign err_o = |bad;
endmodule

// File: rtl/bph_seq.sv
module bph_seq #(
   parameter  int BLOCK_BYTES = 26,
   localparam int CNT_W       = $clog2(BLOCK_BYTES)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic in_valid_i,
   output logic accept_o,
   output logic phase_o,
   output logic last_o,
   output logic active_o
);
   logic [CNT_W-1:0] cnt_q;
   logic             active_q;

   assign accept_o = in_valid_i & active_q & ~start_i;
   assign last_o   = (cnt_q == CNT_W'(BLOCK_BYTES - 1));
   assign phase_o  = cnt_q[0];
   assign active_o = active_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         active_q <= 1'b0;
      end else if (start_i) begin
         cnt_q    <= '0;
         active_q <= 1'b1;
      end else if (accept_o) begin
         if (last_o) begin
            cnt_q    <= '0;
            active_q <= 1'b0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_W'(BLOCK_BYTES - 1)); // R4
   AST_CLOSED_AT_REST: assert property (@(posedge clk) disable iff (!rst_n)
      !active_q |-> cnt_q == '0); // R6
endmodule

// File: rtl/bph_pair_pack.sv
module bph_pair_pack #(
   parameter  int NIB_W = 4,
   localparam int OUT_W = 2 * NIB_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             accept_i,
   input  logic             phase_i,
   input  logic [NIB_W-1:0] nib_i,
   output logic             out_valid_o,
   output logic [OUT_W-1:0] out_byte_o
);
   logic [NIB_W-1:0] hi_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_q        <= '0;
         out_byte_o  <= '0;
         out_valid_o <= 1'b0;
      end else begin
         out_valid_o <= accept_i & phase_i;
         if (accept_i && !phase_i) hi_q <= nib_i;
         if (accept_i && phase_i)  out_byte_o <= {hi_q, nib_i};
      end
   end

   AST_LOW_HALF_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
      (accept_i && phase_i) |=> out_byte_o[NIB_W-1:0] == $past(nib_i)); // R3
endmodule

// File: rtl/bph_err_acc.sv
module bph_err_acc (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic accept_i,
   input  logic last_i,
   input  logic bad_i,
   output logic done_o,
   output logic blk_err_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         blk_err_o <= 1'b0;
         done_o    <= 1'b0;
      end else begin
         done_o <= accept_i & last_i;
         if (start_i)       blk_err_o <= 1'b0;
         else if (accept_i) blk_err_o <= blk_err_o | bad_i;
      end
   end

   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (blk_err_o && !start_i) |=> blk_err_o); // R5
   AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (!blk_err_o && !done_o)); // R6
   AST_BAD_SETS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      (accept_i && bad_i) |=> blk_err_o); // R5
endmodule

// File: rtl/bph_block_dec.sv
module bph_block_dec #(
   parameter  int                IN_W        = 8,
   parameter  int                BLOCK_BYTES = 26,
   parameter  bph_pkg::sym_pol_e POL         = bph_pkg::SYM_HI_IS_ONE,
   localparam int                NIB_W       = IN_W / 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start_i,
   input  logic            in_valid_i,
   input  logic [IN_W-1:0] in_byte_i,
   output logic            out_valid_o,
   output logic [IN_W-1:0] out_byte_o,
   output logic            done_o,
   output logic            blk_err_o
);
   generate
      if (IN_W < 2 || (IN_W % 2) != 0) begin : g_bad_width
         $error("IN_W must be an even number of at least 2");
      end
      if (BLOCK_BYTES < 2 || (BLOCK_BYTES % 2) != 0) begin : g_bad_block
         $error("BLOCK_BYTES must be an even number of at least 2");
      end
   endgenerate

   logic [NIB_W-1:0] nib;
   logic             byte_bad;
   logic             accept, phase, last, active;

   bph_byte_dec #(.IN_W(IN_W), .POL(POL)) u_dec (
      .byte_i (in_byte_i),
      .nib_o  (nib),
      .err_o  (byte_bad)
   );

   bph_seq #(.BLOCK_BYTES(BLOCK_BYTES)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .in_valid_i (in_valid_i),
      .accept_o   (accept),
      .phase_o    (phase),
      .last_o     (last),
      .active_o   (active)
   );

   bph_pair_pack #(.NIB_W(NIB_W)) u_pack (
      .clk         (clk),
      .rst_n       (rst_n),
      .accept_i    (accept),
      .phase_i     (phase),
      .nib_i       (nib),
      .out_valid_o (out_valid_o),
      .out_byte_o  (out_byte_o)
   );

   bph_err_acc u_err (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (start_i),
      .accept_i  (accept),
      .last_i    (last),
      .bad_i     (byte_bad),
      .done_o    (done_o),
      .blk_err_o (blk_err_o)
   );

   AST_DONE_WITH_OUT: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> out_valid_o); // R4
   AST_IDLE_NO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
      !active |=> !out_valid_o); // R7
   AST_IDLE_ERR_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (!active && !start_i) |=> $stable(blk_err_o)); // R7
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o); // R4
endmodule

// File: tb/bph_block_dec_test.sv
`timescale 1ns/100ps
module bph_block_dec_test;
   typedef struct packed {
      logic [7:0] b;
      logic       last;
      logic       err;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic       start, in_valid;
   logic [7:0] in_byte;
   logic       out_valid, done, blk_err;
   logic [7:0] out_byte;

   logic       s2_start, s2_valid;
   logic [7:0] s2_byte;
   logic       o2_valid, o2_done, o2_err;
   logic [7:0] o2_byte;

   int checks = 0;
   int fails  = 0;
   bit finished = 0;
   exp_t q[$];
   exp_t q2[$];

   bph_block_dec uut (
      .clk(clk), .rst_n(rst_n), .start_i(start), .in_valid_i(in_valid),
      .in_byte_i(in_byte), .out_valid_o(out_valid), .out_byte_o(out_byte),
      .done_o(done), .blk_err_o(blk_err));

   bph_block_dec #(.IN_W(8), .BLOCK_BYTES(4), .POL(bph_pkg::SYM_LO_IS_ONE)) uut_inv (
      .clk(clk), .rst_n(rst_n), .start_i(s2_start), .in_valid_i(s2_valid),
      .in_byte_i(s2_byte), .out_valid_o(o2_valid), .out_byte_o(o2_byte),
      .done_o(o2_done), .blk_err_o(o2_err));

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] enc(input logic [3:0] n, input bit inv);
      logic [7:0] r;
      for (int k = 0; k < 4; k++) r[2*k +: 2] = (n[k] ^ inv) ? 2'b10 : 2'b01;
      return r;
   endfunction

   // monitor for the default instance
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         if (out_valid) begin
            if (q.size() == 0) begin
               check(1'b0, "R7 unexpected output", out_byte, 0);
            end else begin
               exp_t e;
               e = q.pop_front();
               check(out_byte == e.b, "R1/R3 data byte", out_byte, e.b);
               check(done == e.last, "R4 done with last byte", done, e.last);
               if (e.last) check(blk_err == e.err, "R5 block error", blk_err, e.err);
            end
         end else if (done) begin
            check(1'b0, "R4 done without output", done, 0);
         end
      end
   end

   // monitor for the short inverted instance
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         if (o2_valid) begin
            if (q2.size() == 0) begin
               check(1'b0, "R7 unexpected output (inv)", o2_byte, 0);
            end else begin
               exp_t e;
               e = q2.pop_front();
               check(o2_byte == e.b, "R1 inverted polarity byte", o2_byte, e.b);
               check(o2_done == e.last, "R4 short block done", o2_done, e.last);
               if (e.last) check(o2_err == e.err, "R5 short block error", o2_err, e.err);
            end
         end
      end
   end

   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic do_start(input bit with_byte, input logic [7:0] b);
      start = 1'b1; in_valid = with_byte; in_byte = b;
      tick();
      start = 1'b0; in_valid = 1'b0;
   endtask

   task automatic put(input logic [7:0] b, input int gap);
      in_byte = b; in_valid = 1'b1;
      tick();
      in_valid = 1'b0;
      repeat (gap) tick();
   endtask

   // send count bytes; bad_at marks a byte with a violated symbol 1
   task automatic run_bytes(input int seed, input int count, input int bad_at,
                            input logic [1:0] bad_sym, input int gap, input bit expect_out);
      logic [3:0] hi, n;
      logic [7:0] b;
      bit         anybad = 0;
      for (int i = 0; i < count; i++) begin
         n = 4'((seed + 5 * i + (i >> 1)) % 16);
         b = enc(n, 1'b0);
         if (i == bad_at) begin
            b[3:2] = bad_sym;
            n[1] = 1'b0;      // R2: violation yields a 0 bit
            anybad = 1;
         end
         if (expect_out && i < 26) begin
            if ((i % 2) == 0) hi = n;
            else q.push_back('{b: {hi, n}, last: (i == 25), err: anybad});
         end
         put(b, (gap > 0 && (i % 3) == 1) ? gap : 0);
      end
   endtask

   task automatic drain(input string req);
      repeat (4) tick();
      check(q.size() == 0, req, q.size(), 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         fails++; checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      start = 0; in_valid = 0; in_byte = 0;
      s2_start = 0; s2_valid = 0; s2_byte = 0;
      repeat (3) tick();
      // R8: reset state
      check(out_valid == 0 && done == 0 && blk_err == 0, "R8 reset outputs",
            {out_valid, done, blk_err}, 0);
      rst_n = 1'b1;
      tick();
      check(out_valid == 0 && done == 0 && blk_err == 0, "R8 after release",
            {out_valid, done, blk_err}, 0);

      // R7: bytes before any start are ignored, even bad ones
      run_bytes(3, 4, 1, 2'b00, 0, 1'b0);
      drain("R7 no output before start");
      check(blk_err == 0, "R7 error untouched before start", blk_err, 0);

      // R1 R3 R4: clean block back to back
      do_start(0, 0);
      run_bytes(0, 26, -1, 2'b00, 0, 1'b1);
      drain("R4 all bytes of clean block emitted");

      // R9: same kind of block with idle gaps
      do_start(0, 0);
      run_bytes(7, 26, -1, 2'b00, 2, 1'b1);
      drain("R9 gapped block emitted");

      // R2 R5: violation in last byte
      do_start(0, 0);
      run_bytes(11, 26, 25, 2'b11, 0, 1'b1);
      drain("R2 block with bad last byte emitted");
      repeat (3) tick();
      check(blk_err == 1, "R5 error held after done", blk_err, 1);

      // R7: bytes after block completion ignored, error kept
      run_bytes(2, 6, -1, 2'b00, 0, 1'b0);
      drain("R7 no output after block end");
      check(blk_err == 1, "R7 error unchanged after block end", blk_err, 1);

      // R6: start clears error; violation in first byte of new block
      do_start(0, 0);
      check(blk_err == 0, "R6 start clears error", blk_err, 0);
      run_bytes(4, 26, 0, 2'b00, 1, 1'b1);
      drain("R2 block with bad first byte emitted");

      // R6: abort a partial block (7 bytes, bad one inside), restart cleanly
      do_start(0, 0);
      run_bytes(9, 7, 2, 2'b11, 0, 1'b1);
      repeat (2) tick();
      // the partial block pushed 3 pairs; they are consumed, item flags not last
      do_start(0, 0);
      run_bytes(13, 26, -1, 2'b00, 0, 1'b1);
      drain("R6 restart after abort");

      // R6: byte presented with start is dropped
      do_start(1, 8'h00);   // all-violation byte; must not count or flag
      run_bytes(5, 26, -1, 2'b00, 0, 1'b1);
      drain("R6 byte with start dropped");

      // R1 R4: inverted polarity, 4-byte blocks
      s2_start = 1; tick(); s2_start = 0;
      begin
         logic [3:0] n [4];
         n[0] = 4'hA; n[1] = 4'h3; n[2] = 4'h0; n[3] = 4'hF;
         q2.push_back('{b: {n[0], n[1]}, last: 1'b0, err: 1'b0});
         q2.push_back('{b: {n[2], n[3]}, last: 1'b1, err: 1'b0});
         for (int i = 0; i < 4; i++) begin
            s2_byte = enc(n[i], 1'b1); s2_valid = 1; tick(); s2_valid = 0;
         end
      end
      repeat (4) tick();
      check(q2.size() == 0, "R4 short block complete", q2.size(), 0);
      check(o2_err == 0, "R5 short block clean", o2_err, 0);

      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule